// File: doc/BRIEF.md
# Power Mode Sequencer

This block is a state machine that follows a device through its power modes: shutdown, sleep, active, a hardware-reset hold and a short soft-reset phase. Its inputs are single-cycle events that have already been decoded: wake, sleep-to-active, sleep entry, shutdown entry, soft reset and hardware reset. Each event that the current mode accepts starts a timed transition. The block reports the mode it is in, a busy flag while a transition runs, and a ready flag. Ready tells the command path that traffic may be accepted.

Every transition has its own fixed latency, counted by one down-counter on the 32 MHz system clock. The latency depends on the source mode and on the event that started it, so leaving sleep on a wake event takes longer than leaving it on a sleep-to-active event. All latencies are parameters in clock cycles. The defaults are 6 ms from shutdown to active, 230 µs for sleep-to-active, 1 ms for a wake from sleep, 100 µs for sleep entry, 20 ms for shutdown entry, 1 ms for soft reset and 75 ms for the hardware-reset hold.

Top module: `pwr_mode_seq`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, after that edge `mode_o` is SHUTDOWN (code 0), and `ready_o` and `busy_o` are both 0.
- R2: In SHUTDOWN, a wake event starts a transition. `ready_o` rises and `mode_o` becomes ACTIVE (code 2) exactly `WAKE_SHUT_CYC` cycles after the edge that sampled the event.
- R3: In SLEEP (code 1), a sleep-to-active event reaches ACTIVE after `S2A_CYC` cycles. A wake event reaches ACTIVE after `WAKE_SLP_CYC` cycles. When both arrive in the same cycle, the wake event wins.
- R4: In ACTIVE, a sleep-entry event reaches SLEEP after `SLP_ENTRY_CYC` cycles.
- R5: In ACTIVE, a shutdown-entry event reaches SHUTDOWN after `SHUT_ENTRY_CYC` cycles. It wins over sleep entry and soft reset when they arrive in the same cycle.
- R6: In ACTIVE, a soft-reset event shows `mode_o` = SOFTRST (code 4) for `SOFT_RST_CYC` cycles. The block then returns to ACTIVE with `ready_o` high.
- R7: A hardware-reset event in any steady mode shows `mode_o` = HWRESET (code 3) for `HW_RST_CYC` cycles. The block then settles in SHUTDOWN with `ready_o` low. This event wins over every other event in the same cycle.
- R8: Any event that arrives while `busy_o` is high is ignored. It does not change the destination or the latency of the transition in progress.
- R9: `ready_o` is high only in steady ACTIVE. It falls at the same edge where a transition starts, and `busy_o` is high for the whole transition.
- R10: An event that the current steady mode does not accept leaves `mode_o`, `ready_o` and `busy_o` unchanged. Examples are sleep-to-active, sleep entry or soft reset in SHUTDOWN, and wake in ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_wake_i | input | 1 | Wake event, one cycle |
| ev_s2a_i | input | 1 | Sleep-to-active event, one cycle |
| ev_sleep_i | input | 1 | Sleep-entry event, one cycle |
| ev_shut_i | input | 1 | Shutdown-entry event, one cycle |
| ev_softrst_i | input | 1 | Soft-reset request, one cycle |
| ev_hwrst_i | input | 1 | Hardware-reset event, one cycle |
| mode_o | output | 3 | Current mode code (0 shutdown, 1 sleep, 2 active, 3 hw reset, 4 soft reset) |
| ready_o | output | 1 | Command traffic may be accepted |
| busy_o | output | 1 | A transition is in progress |

## Verification
The assertions assume that the event inputs are driven to known values at every sampled edge. They also assume that `rst_n` is held low at the first clock edge, so that the mode has a defined value before any property looks at `$past`. The bench raises each event for exactly one clock cycle and changes events only on the falling edge. It asserts reset before its first check, and it never lets inputs float. Events that are sent during transitions are likewise one-cycle pulses placed well inside the transition window.

// File: rtl/pwrseq_pkg.sv
// Package: shared mode and transition encodings for the power mode sequencer.
// Assumes: mode codes are visible at the top-level port and must stay fixed.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        MODE_SHUTDOWN = 3'd0,
        MODE_SLEEP    = 3'd1,
        MODE_ACTIVE   = 3'd2,
        MODE_HWRESET  = 3'd3,
        MODE_SOFTRST  = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        XF_WAKE_SHUT  = 3'd0,
        XF_S2A        = 3'd1,
        XF_WAKE_SLP   = 3'd2,
        XF_SLP_ENTRY  = 3'd3,
        XF_SHUT_ENTRY = 3'd4,
        XF_SOFTRST    = 3'd5,
        XF_HWRST      = 3'd6
    } xfer_e;

    // Mode the block settles in once a transition of the given kind completes.
    function automatic mode_e xfer_dest(input xfer_e k);
        case (k)
            XF_WAKE_SHUT, XF_S2A, XF_WAKE_SLP, XF_SOFTRST: xfer_dest = MODE_ACTIVE;
            XF_SLP_ENTRY:                                 xfer_dest = MODE_SLEEP;
            default:                                      xfer_dest = MODE_SHUTDOWN;
        endcase
    endfunction

    // Mode shown on the port while a transition of the given kind is in progress.
    function automatic mode_e xfer_show(input xfer_e k, input mode_e src);
        case (k)
            XF_HWRST:   xfer_show = MODE_HWRESET;
            XF_SOFTRST: xfer_show = MODE_SOFTRST;
            default:    xfer_show = src;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_arbiter.sv
// Module: event arbiter. Picks at most one accepted event for the current
// steady mode, by fixed priority, and gives the counter preload for it.
// Assumes: events are single-cycle pulses; every delay parameter is at least 1.
module pwrseq_arbiter
    import pwrseq_pkg::*;
#(
    parameter int unsigned CW             = 8,
    parameter int unsigned WAKE_SHUT_CYC  = 10,
    parameter int unsigned S2A_CYC        = 10,
    parameter int unsigned WAKE_SLP_CYC   = 10,
    parameter int unsigned SLP_ENTRY_CYC  = 10,
    parameter int unsigned SHUT_ENTRY_CYC = 10,
    parameter int unsigned SOFT_RST_CYC   = 10,
    parameter int unsigned HW_RST_CYC     = 10
) (
    input  logic          in_xfer,
    input  mode_e         mode,
    input  logic          ev_wake,
    input  logic          ev_s2a,
    input  logic          ev_sleep,
    input  logic          ev_shut,
    input  logic          ev_softrst,
    input  logic          ev_hwrst,
    output logic          go,
    output xfer_e         kind,
    output logic [CW-1:0] load_val
);

    // Priority selection of the accepted event; nothing is accepted mid-transition.
    always_comb begin
        go   = 1'b0;
        kind = XF_HWRST;
        if (!in_xfer) begin
            if (ev_hwrst) begin
                go   = 1'b1;
                kind = XF_HWRST;
            end else begin
                case (mode)
                    MODE_SHUTDOWN: if (ev_wake) begin
                        go = 1'b1; kind = XF_WAKE_SHUT;
                    end
                    MODE_SLEEP: if (ev_wake) begin
                        go = 1'b1; kind = XF_WAKE_SLP;
                    end else if (ev_s2a) begin
                        go = 1'b1; kind = XF_S2A;
                    end
                    MODE_ACTIVE: if (ev_shut) begin
                        go = 1'b1; kind = XF_SHUT_ENTRY;
                    end else if (ev_sleep) begin
                        go = 1'b1; kind = XF_SLP_ENTRY;
                    end else if (ev_softrst) begin
                        go = 1'b1; kind = XF_SOFTRST;
                    end
                    default: go = 1'b0;
                endcase
            end
        end
    end

    // Counter preload: latency minus one, because the load edge counts as the first cycle.
    always_comb begin
        case (kind)
            XF_WAKE_SHUT:  load_val = CW'(WAKE_SHUT_CYC - 1);
            XF_S2A:        load_val = CW'(S2A_CYC - 1);
            XF_WAKE_SLP:   load_val = CW'(WAKE_SLP_CYC - 1);
            XF_SLP_ENTRY:  load_val = CW'(SLP_ENTRY_CYC - 1);
            XF_SHUT_ENTRY: load_val = CW'(SHUT_ENTRY_CYC - 1);
            XF_SOFTRST:    load_val = CW'(SOFT_RST_CYC - 1);
            default:       load_val = CW'(HW_RST_CYC - 1);
        endcase
    end

endmodule

// File: rtl/pwrseq_timer.sv
// Module: shared down-counter that times every transition.
// Assumes: a load always wins over counting; the counter rests at zero.
module pwrseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pwr_mode_seq.sv
// Module: power mode sequencer top. Holds the steady mode and the running
// transition, and drives mode, ready and busy.
// Assumes: 32 MHz clock; all latencies are given in clock cycles and are >= 1.
module pwr_mode_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned WAKE_SHUT_CYC  = 192000,
    parameter int unsigned S2A_CYC        = 7360,
    parameter int unsigned WAKE_SLP_CYC   = 32000,
    parameter int unsigned SLP_ENTRY_CYC  = 3200,
    parameter int unsigned SHUT_ENTRY_CYC = 640000,
    parameter int unsigned SOFT_RST_CYC   = 32000,
    parameter int unsigned HW_RST_CYC     = 2400000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_wake_i,
    input  logic       ev_s2a_i,
    input  logic       ev_sleep_i,
    input  logic       ev_shut_i,
    input  logic       ev_softrst_i,
    input  logic       ev_hwrst_i,
    output logic [2:0] mode_o,
    output logic       ready_o,
    output logic       busy_o
);

    // Largest latency; sets the counter width.
    localparam int unsigned MAX_A  = (WAKE_SHUT_CYC > S2A_CYC) ? WAKE_SHUT_CYC : S2A_CYC;
    localparam int unsigned MAX_B  = (WAKE_SLP_CYC > SLP_ENTRY_CYC) ? WAKE_SLP_CYC : SLP_ENTRY_CYC;
    localparam int unsigned MAX_C  = (SHUT_ENTRY_CYC > SOFT_RST_CYC) ? SHUT_ENTRY_CYC : SOFT_RST_CYC;
    localparam int unsigned MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_CH = (MAX_C > HW_RST_CYC) ? MAX_C : HW_RST_CYC;
    localparam int unsigned MAX_ALL = (MAX_AB > MAX_CH) ? MAX_AB : MAX_CH;
    localparam int unsigned CW     = (MAX_ALL < 2) ? 1 : $clog2(MAX_ALL);

    mode_e         steady_q;
    xfer_e         kind_q;
    logic          in_xfer_q;
    logic          go;
    xfer_e         go_kind;
    logic [CW-1:0] load_val;
    logic          zero;

    pwrseq_arbiter #(
        .CW(CW), .WAKE_SHUT_CYC(WAKE_SHUT_CYC), .S2A_CYC(S2A_CYC),
        .WAKE_SLP_CYC(WAKE_SLP_CYC), .SLP_ENTRY_CYC(SLP_ENTRY_CYC),
        .SHUT_ENTRY_CYC(SHUT_ENTRY_CYC), .SOFT_RST_CYC(SOFT_RST_CYC),
        .HW_RST_CYC(HW_RST_CYC)
    ) u_arb (
        .in_xfer(in_xfer_q), .mode(steady_q),
        .ev_wake(ev_wake_i), .ev_s2a(ev_s2a_i), .ev_sleep(ev_sleep_i),
        .ev_shut(ev_shut_i), .ev_softrst(ev_softrst_i), .ev_hwrst(ev_hwrst_i),
        .go(go), .kind(go_kind), .load_val(load_val)
    );

    pwrseq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(go), .load_val(load_val), .zero(zero)
    );

    // Start a transition on an accepted event; settle in the destination when the count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steady_q  <= MODE_SHUTDOWN;
            kind_q    <= XF_HWRST;
            in_xfer_q <= 1'b0;
        end else if (go) begin
            kind_q    <= go_kind;
            in_xfer_q <= 1'b1;
        end else if (in_xfer_q && zero) begin
            steady_q  <= xfer_dest(kind_q);
            in_xfer_q <= 1'b0;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        mode_o  = in_xfer_q ? xfer_show(kind_q, steady_q) : steady_q;
        busy_o  = in_xfer_q;
        ready_o = !in_xfer_q && (steady_q == MODE_ACTIVE);
    end

endmodule

// File: rtl/pwr_mode_seq_chk.sv
// Module: assertion checker for the power mode sequencer, bound to the top.
// Assumes: rst_n is low at the first clock edge.
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_o,
    input logic       ready_o,
    input logic       busy_o
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 3'd0 && !ready_o && !busy_o));

    assert_ready_only_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (mode_o == 3'd2 && !busy_o));

    assert_busy_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ready_o);

    assert_mode_held_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mode_o));

    assert_hwrst_ends_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 3'd3 && mode_o != 3'd3) |-> (mode_o == 3'd0 && !busy_o && !ready_o));

    assert_softrst_ends_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 3'd4 && mode_o != 3'd4) |-> (mode_o == 3'd2 && ready_o));

    assert_mode_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .ready_o(ready_o), .busy_o(busy_o)
);

// File: tb/tb_pwr_mode_seq.sv
// Bench: directed scenarios for the power mode sequencer, with short latencies.
module tb_pwr_mode_seq;

    localparam int CLK_PERIOD = 32;
    localparam int D_WS  = 20;
    localparam int D_S2A = 7;
    localparam int D_WSL = 11;
    localparam int D_SLP = 5;
    localparam int D_SH  = 25;
    localparam int D_SR  = 9;
    localparam int D_HW  = 30;

    // Event bit positions inside ev
    localparam int E_WAKE = 0, E_S2A = 1, E_SLP = 2, E_SHUT = 3, E_SRST = 4, E_HW = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ev = '0;
    logic [2:0] mode_o;
    logic       ready_o, busy_o;
    int         n_chk = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_seq #(
        .WAKE_SHUT_CYC(D_WS), .S2A_CYC(D_S2A), .WAKE_SLP_CYC(D_WSL),
        .SLP_ENTRY_CYC(D_SLP), .SHUT_ENTRY_CYC(D_SH), .SOFT_RST_CYC(D_SR),
        .HW_RST_CYC(D_HW)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_wake_i(ev[E_WAKE]), .ev_s2a_i(ev[E_S2A]), .ev_sleep_i(ev[E_SLP]),
        .ev_shut_i(ev[E_SHUT]), .ev_softrst_i(ev[E_SRST]), .ev_hwrst_i(ev[E_HW]),
        .mode_o(mode_o), .ready_o(ready_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive an event pattern for one sampled edge; returns at the following negedge.
    task automatic pulse(input logic [5:0] pat);
        @(negedge clk);
        ev = pat;
        @(negedge clk);
        ev = '0;
    endtask

    // After a pulse: checks busy/ready right away, then counts cycles until busy falls.
    // An optional event pattern is injected mid-transition.
    task automatic run_xfer(input string req, input int exp_lat, input int exp_mode,
                            input int exp_busy_mode, input logic [5:0] mid_pat);
        int n = 0;
        chk(busy_o == 1'b1, req, busy_o, 1);
        chk(ready_o == 1'b0, "R9", ready_o, 0);
        chk(mode_o == exp_busy_mode[2:0], req, mode_o, exp_busy_mode);
        n = 0;
        while (busy_o && n < 1000) begin
            if (n == 2 && mid_pat != '0) ev = mid_pat;
            else ev = '0;
            @(negedge clk);
            n++;
        end
        ev = '0;
        chk(n == exp_lat, req, n, exp_lat);
        chk(mode_o == exp_mode[2:0], req, mode_o, exp_mode);
        chk(ready_o == (exp_mode == 2), req, ready_o, exp_mode == 2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(mode_o == 3'd0 && !ready_o && !busy_o, "R1", mode_o, 0);
    endtask

    task automatic t_wake_shut();
        pulse(6'b1 << E_WAKE);
        run_xfer("R2", D_WS, 2, 0, '0);
    endtask

    task automatic t_sleep_entry();
        pulse(6'b1 << E_SLP);
        run_xfer("R4", D_SLP, 1, 2, '0);
    endtask

    task automatic t_s2a();
        pulse(6'b1 << E_S2A);
        run_xfer("R3", D_S2A, 2, 1, '0);
    endtask

    task automatic t_wake_sleep_both();
        pulse((6'b1 << E_WAKE) | (6'b1 << E_S2A));
        run_xfer("R3", D_WSL, 2, 1, '0);
    endtask

    task automatic t_softrst();
        pulse(6'b1 << E_SRST);
        run_xfer("R6", D_SR, 2, 4, '0);
    endtask

    task automatic t_shut_priority();
        pulse((6'b1 << E_SHUT) | (6'b1 << E_SLP) | (6'b1 << E_SRST));
        run_xfer("R5", D_SH, 0, 2, '0);
    endtask

    task automatic t_hw_priority();
        pulse((6'b1 << E_HW) | (6'b1 << E_WAKE));
        run_xfer("R7", D_HW, 0, 3, '0);
    endtask

    task automatic t_ignore_midway();
        // Sleep entry with a hardware reset injected midway: still ends in SLEEP on time.
        pulse(6'b1 << E_SLP);
        run_xfer("R8", D_SLP, 1, 2, 6'b1 << E_HW);
        // Wake from sleep with shutdown request midway.
        pulse(6'b1 << E_WAKE);
        run_xfer("R8", D_WSL, 2, 1, 6'b1 << E_SHUT);
    endtask

    task automatic t_illegal_events();
        // In ACTIVE: wake and sleep-to-active are not accepted.
        pulse((6'b1 << E_WAKE) | (6'b1 << E_S2A));
        chk(mode_o == 3'd2 && ready_o && !busy_o, "R10", mode_o, 2);
    endtask

    task automatic t_illegal_shutdown();
        pulse((6'b1 << E_S2A) | (6'b1 << E_SLP) | (6'b1 << E_SRST) | (6'b1 << E_SHUT));
        chk(mode_o == 3'd0 && !ready_o && !busy_o, "R10", mode_o, 0);
    endtask

    task automatic t_hw_from_sleep();
        pulse(6'b1 << E_HW);
        run_xfer("R7", D_HW, 0, 3, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        t_illegal_shutdown();
        t_wake_shut();
        t_illegal_events();
        t_softrst();
        t_sleep_entry();
        t_s2a();
        t_sleep_entry();
        t_wake_sleep_both();
        t_ignore_midway();
        t_shut_priority();
        t_wake_shut();
        t_sleep_entry();
        t_hw_from_sleep();
        t_wake_shut();
        t_hw_priority();
        // Reset taken mid-transition returns to SHUTDOWN.
        pulse(6'b1 << E_WAKE);
        do_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule